// File: doc/BRIEF.md
# Double-Rate Command/Address Capture and Decode

This block sits behind the command/address receivers of a graphics memory device model. A command is taken together with the first half of a ten-pin address word on the true-clock rising event. The second half of the address word arrives on the same pins at the next complementary-clock rising event. Once both halves are in, the block rebuilds the sixteen logical address bits and the four bank bits. It then presents one decoded command for a single cycle. For an activate, that command carries the row. For a read or write, it carries two independent column addresses that share one bank, a burst-half select and the auto-precharge flag.

Both clock events come in as one-cycle strobes on a fast internal clock. A three-state capture machine drives the sequence. In state IDLE it waits for a true-clock event and moves to HALF. In HALF it waits for the complementary event and moves to EMIT. A new true-clock event while in HALF restarts the capture and stays in HALF. From EMIT it returns to IDLE, or it moves to HALF if a true-clock event comes in that same cycle. Density and organisation selects set how wide the row is and which rows do not exist. A small per-bank memory records whether the last activate to each bank opened a row that does not exist. A later read or write to that bank is then flagged as well.

Top module: `cmd_addr_decoder`

## Requirements
- R1: A synchronous active-low reset leaves `dec_valid` low and drops any half-captured command, so a complementary event that arrives after reset produces no output.
- R2: `{ras_n,cas_n,we_n}` sampled on the true-clock event decode as follows: 011 is ACTIVATE (code 1), 101 is READ (code 2), 100 is WRITE (code 3), 111 is NOP (code 0), and every other combination is OTHER (code 4), all on `dec_cmd`.
- R3: `ca_pins[9:0]` carry BA3,BA2,BA1,BA0,A14,A12,A11,A10,A9,A8 on the true-clock event, and A3,A4,A5,A2,A15,A13,A6,A0,A1,A7 on the complementary event, from pin 9 down to pin 0. `dec_bank` is BA3:0.
- R4: `dec_valid` goes high in the cycle after the complementary event is captured, stays high for exactly one cycle, and a complementary event with no pending command is ignored.
- R5: For READ and WRITE, `dec_col_lo` = A5:0 and `dec_col_hi` = {A15,A14,A13,A12,A9,A7}. For other commands both are zero.
- R6: `dec_half` equals A6 on READ/WRITE when `ddr_mode`=1, and is 0 when `ddr_mode`=0 or for other commands.
- R7: `dec_autopre` equals A8 on READ/WRITE and is 0 for every other command.
- R8: On ACTIVATE, `dec_row` holds the low row bits of A. Density codes 0..4 (4G,6G,8G,12G,16G) give widths 13,14,14,15,15 bits, with one more bit when `x16_mode`=1, and the unused upper bits are zero. Codes 5..7 act as 16G. `dec_row` is zero for other commands.
- R9: An ACTIVATE raises `dec_illegal` when the density is 6G or 12G and the two top bits of the row are both 1.
- R10: A READ or WRITE raises `dec_illegal` when the most recent ACTIVATE to the same bank was itself illegal. Banks never activated since reset count as legal.
- R11: A true-clock event while waiting for the second address half discards the first capture and starts over with the new command and pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ck_rise | input | 1 | True-clock rising event strobe |
| ckc_rise | input | 1 | Complementary-clock rising event strobe |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ca_pins | input | 10 | Shared two-phase address pins |
| ddr_mode | input | 1 | 1 = double-rate data mode, 0 = quad-rate |
| x16_mode | input | 1 | 1 = x16 organisation, 0 = x32 |
| density | input | 3 | Density code 0..4 |
| dec_valid | output | 1 | Decoded command strobe |
| dec_cmd | output | 3 | Command code |
| dec_bank | output | 4 | Bank |
| dec_row | output | 16 | Row (activate only) |
| dec_col_lo | output | 6 | Lower-half column |
| dec_col_hi | output | 6 | Upper-half column |
| dec_half | output | 1 | Burst-half select |
| dec_autopre | output | 1 | Auto-precharge flag |
| dec_illegal | output | 1 | Access to a missing row |

## Verification
The hardest case to reach is R10. A read or write carries no row, so it can only be flagged through state left behind by an earlier activate to the same bank, with a different density context in force. The sweep runs every strobe combination across both modes, both organisations and all densities, and the bench keeps its own per-bank record of illegal activates. Reads that follow illegal activates in earlier sweep steps are therefore predicted and checked. Directed sequences also pair an illegal activate with reads to that bank and to a neighbouring bank. Separate directed sequences cover the restart in HALF and a reset between the two halves.

// File: rtl/cad_pkg.sv
package cad_pkg;
    localparam int PIN_W  = 10;
    localparam int BANK_W = 4;
    localparam int ADDR_W = 16;
    localparam int COL_W  = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HALF = 2'd1,
        ST_EMIT = 2'd2
    } cap_state_e;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_OTHER = 3'd4
    } cmd_e;
endpackage

// File: rtl/cad_capture_fsm.sv
module cad_capture_fsm
    import cad_pkg::*;
#(
    parameter int PINS = PIN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ck_rise,
    input  logic            ckc_rise,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [PINS-1:0] pins,
    output logic            emit,
    output logic [2:0]      strobes,
    output logic [PINS-1:0] phase1,
    output logic [PINS-1:0] phase2
);
    cap_state_e state_q, state_d;
    logic load_first, load_second;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ck_rise) state_d = ST_HALF;
            ST_HALF: begin
                if (ck_rise)       state_d = ST_HALF;   // restart (R11)
                else if (ckc_rise) state_d = ST_EMIT;
            end
            ST_EMIT: state_d = ck_rise ? ST_HALF : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load_first  = ck_rise;
    assign load_second = (state_q == ST_HALF) && !ck_rise && ckc_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobes <= 3'b111;
            phase1  <= '0;
            phase2  <= '0;
        end else begin
            if (load_first) begin
                strobes <= {ras_n, cas_n, we_n};
                phase1  <= pins;
            end
            if (load_second) phase2 <= pins;
        end
    end

    always_comb begin
        emit = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/cad_addr_map.sv
module cad_addr_map
    import cad_pkg::*;
#(
    parameter int PINS  = PIN_W,
    parameter int BANKS = BANK_W,
    parameter int AW    = ADDR_W
) (
    input  logic [PINS-1:0]  phase1,
    input  logic [PINS-1:0]  phase2,
    output logic [BANKS-1:0] bank,
    output logic [AW-1:0]    addr
);
    assign bank = phase1[PINS-1 -: BANKS];

    always_comb begin
        addr      = '0;
        addr[15]  = phase2[5];
        addr[14]  = phase1[5];
        addr[13]  = phase2[4];
        addr[12]  = phase1[4];
        addr[11]  = phase1[3];
        addr[10]  = phase1[2];
        addr[9]   = phase1[1];
        addr[8]   = phase1[0];
        addr[7]   = phase2[0];
        addr[6]   = phase2[3];
        addr[5]   = phase2[7];
        addr[4]   = phase2[8];
        addr[3]   = phase2[9];
        addr[2]   = phase2[6];
        addr[1]   = phase2[1];
        addr[0]   = phase2[2];
    end
endmodule

// File: rtl/cad_field_decode.sv
module cad_field_decode
    import cad_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = COL_W
) (
    input  logic [2:0]    strobes,
    input  logic [AW-1:0] addr,
    input  logic          ddr_mode,
    input  logic          x16_mode,
    input  logic [2:0]    density,
    output cmd_e          cmd,
    output logic [AW-1:0] row,
    output logic [CW-1:0] col_lo,
    output logic [CW-1:0] col_hi,
    output logic          half,
    output logic          autopre,
    output logic          row_bad
);
    logic [4:0]    row_w;
    logic [3:0]    top_idx;
    logic [AW-1:0] row_mask;
    logic          holey;
    logic          is_col;

    always_comb begin
        unique case (strobes)
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b111:  cmd = CMD_NOP;
            default: cmd = CMD_OTHER;
        endcase
    end

    always_comb begin
        unique case (density)
            3'd0:       row_w = 5'd13;
            3'd1, 3'd2: row_w = 5'd14;
            default:    row_w = 5'd15;
        endcase
        row_w   = row_w + {4'd0, x16_mode};
        top_idx = 4'(row_w - 5'd1);
        holey   = (density == 3'd1) || (density == 3'd3);
    end

    generate
        for (genvar i = 0; i < AW; i++) begin : g_mask
            assign row_mask[i] = (5'(i) < row_w);
        end
    endgenerate

    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    always_comb begin
        row     = (cmd == CMD_ACT) ? (addr & row_mask) : '0;
        row_bad = (cmd == CMD_ACT) && holey && addr[top_idx] && addr[top_idx - 4'd1];
        col_lo  = is_col ? addr[5:0] : '0;
        col_hi  = is_col ? {addr[15], addr[14], addr[13], addr[12], addr[9], addr[7]} : '0;
        half    = is_col && ddr_mode && addr[6];
        autopre = is_col && addr[8];
    end
endmodule

// File: rtl/cad_bank_guard.sv
module cad_bank_guard
    import cad_pkg::*;
#(
    parameter int BANKS = BANK_W,
    localparam int NBANK = 1 << BANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BANKS-1:0] bank,
    input  logic             bad_in,
    output logic             bad_out
);
    logic [NBANK-1:0] bad_q;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (!rst_n)                              bad_q[b] <= 1'b0;
                else if (wr_en && (bank == BANKS'(b)))   bad_q[b] <= bad_in;
            end
        end
    endgenerate

    assign bad_out = bad_q[bank];
endmodule

// File: rtl/cmd_addr_decoder.sv
module cmd_addr_decoder
    import cad_pkg::*;
#(
    parameter int PINS  = PIN_W,
    parameter int BANKS = BANK_W,
    parameter int AW    = ADDR_W,
    parameter int CW    = COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ck_rise,
    input  logic             ckc_rise,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [PINS-1:0]  ca_pins,
    input  logic             ddr_mode,
    input  logic             x16_mode,
    input  logic [2:0]       density,
    output logic             dec_valid,
    output logic [2:0]       dec_cmd,
    output logic [BANKS-1:0] dec_bank,
    output logic [AW-1:0]    dec_row,
    output logic [CW-1:0]    dec_col_lo,
    output logic [CW-1:0]    dec_col_hi,
    output logic             dec_half,
    output logic             dec_autopre,
    output logic             dec_illegal
);
    logic             emit;
    logic [2:0]       strobes;
    logic [PINS-1:0]  ph1, ph2;
    logic [BANKS-1:0] bank;
    logic [AW-1:0]    addr, row;
    logic [CW-1:0]    col_lo, col_hi;
    logic             half, autopre, row_bad, bank_bad;
    cmd_e             cmd;

    cad_capture_fsm #(.PINS(PINS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ck_rise(ck_rise), .ckc_rise(ckc_rise),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .pins(ca_pins),
        .emit(emit), .strobes(strobes), .phase1(ph1), .phase2(ph2)
    );

    cad_addr_map #(.PINS(PINS), .BANKS(BANKS), .AW(AW)) u_map (
        .phase1(ph1), .phase2(ph2), .bank(bank), .addr(addr)
    );

    cad_field_decode #(.AW(AW), .CW(CW)) u_dec (
        .strobes(strobes), .addr(addr), .ddr_mode(ddr_mode),
        .x16_mode(x16_mode), .density(density), .cmd(cmd), .row(row),
        .col_lo(col_lo), .col_hi(col_hi), .half(half), .autopre(autopre),
        .row_bad(row_bad)
    );

    cad_bank_guard #(.BANKS(BANKS)) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(emit && (cmd == CMD_ACT)),
        .bank(bank), .bad_in(row_bad), .bad_out(bank_bad)
    );

    always_comb begin
        dec_valid   = emit;
        dec_cmd     = emit ? cmd    : CMD_NOP;
        dec_bank    = emit ? bank   : '0;
        dec_row     = emit ? row    : '0;
        dec_col_lo  = emit ? col_lo : '0;
        dec_col_hi  = emit ? col_hi : '0;
        dec_half    = emit && half;
        dec_autopre = emit && autopre;
        dec_illegal = emit && (row_bad ||
                      (((cmd == CMD_RD) || (cmd == CMD_WR)) && bank_bad));
    end
endmodule

// File: rtl/cad_checker.sv
module cad_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ckc_rise,
    input logic        ddr_mode,
    input logic        dec_valid,
    input logic [2:0]  dec_cmd,
    input logic [15:0] dec_row,
    input logic        dec_half,
    input logic        dec_autopre,
    input logic        dec_illegal
);
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_valid_after_ckc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(ckc_rise));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rst_n));

    assert_qdr_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ddr_mode) |-> !dec_half);

    assert_autopre_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_cmd != 3'd2) && (dec_cmd != 3'd3)) |-> !dec_autopre);

    assert_row_only_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_cmd != 3'd1)) |-> (dec_row == 16'd0));

    assert_illegal_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |-> dec_valid);

    assert_illegal_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |-> ((dec_cmd == 3'd1) || (dec_cmd == 3'd2) || (dec_cmd == 3'd3)));
endmodule

bind cmd_addr_decoder cad_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ckc_rise(ckc_rise), .ddr_mode(ddr_mode),
    .dec_valid(dec_valid), .dec_cmd(dec_cmd), .dec_row(dec_row),
    .dec_half(dec_half), .dec_autopre(dec_autopre), .dec_illegal(dec_illegal)
);

// File: tb/cmd_addr_decoder_test.sv
module cmd_addr_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ck_rise = 1'b0, ckc_rise = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [9:0]  ca_pins = '0;
    logic        ddr_mode = 1'b0, x16_mode = 1'b0;
    logic [2:0]  density = 3'd0;
    logic        dec_valid, dec_half, dec_autopre, dec_illegal;
    logic [2:0]  dec_cmd;
    logic [3:0]  dec_bank;
    logic [15:0] dec_row;
    logic [5:0]  dec_col_lo, dec_col_hi;

    int total = 0;
    int bad = 0;
    bit tbl_bad [16];

    always #2 clk = ~clk;

    cmd_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .ck_rise(ck_rise), .ckc_rise(ckc_rise),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ca_pins(ca_pins),
        .ddr_mode(ddr_mode), .x16_mode(x16_mode), .density(density),
        .dec_valid(dec_valid), .dec_cmd(dec_cmd), .dec_bank(dec_bank),
        .dec_row(dec_row), .dec_col_lo(dec_col_lo), .dec_col_hi(dec_col_hi),
        .dec_half(dec_half), .dec_autopre(dec_autopre), .dec_illegal(dec_illegal)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] first_half(input logic [3:0] b, input logic [15:0] a);
        return {b[3], b[2], b[1], b[0], a[14], a[12], a[11], a[10], a[9], a[8]};
    endfunction

    function automatic logic [9:0] second_half(input logic [15:0] a);
        return {a[3], a[4], a[5], a[2], a[15], a[13], a[6], a[0], a[1], a[7]};
    endfunction

    task automatic send(input logic [2:0] s, input logic [3:0] b, input logic [15:0] a);
        @(negedge clk);
        ck_rise = 1'b1; {ras_n, cas_n, we_n} = s; ca_pins = first_half(b, a);
        @(negedge clk);
        ck_rise = 1'b0; ckc_rise = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
        ca_pins = second_half(a);
        @(negedge clk);
        ckc_rise = 1'b0; ca_pins = '0;
        #1;
    endtask

    // Full expected-value check of one transaction, sampled in the emit cycle.
    task automatic send_check(input logic [2:0] s, input logic [3:0] b, input logic [15:0] a);
        int code, w, row_e, bad_e, il_e;
        bit act, col;
        send(s, b, a);
        case (s)
            3'b011: code = 1;
            3'b101: code = 2;
            3'b100: code = 3;
            3'b111: code = 0;
            default: code = 4;
        endcase
        act = (code == 1);
        col = (code == 2) || (code == 3);
        case (density)
            3'd0: w = 13;
            3'd1, 3'd2: w = 14;
            default: w = 15;
        endcase
        w = w + int'(x16_mode);
        row_e = act ? (int'(a) % (1 << w)) : 0;
        bad_e = (act && (density == 3'd1 || density == 3'd3) &&
                 (((int'(a) >> (w - 2)) % 4) == 3)) ? 1 : 0;
        il_e  = act ? bad_e : (col ? int'(tbl_bad[b]) : 0);
        chk(dec_valid == 1'b1, "R4 valid", int'(dec_valid), 1);
        chk(int'(dec_cmd) == code, "R2 cmd", int'(dec_cmd), code);
        chk(dec_bank == b, "R3 bank", int'(dec_bank), int'(b));
        chk(int'(dec_row) == row_e, "R8 row", int'(dec_row), row_e);
        chk(int'(dec_col_lo) == (col ? int'(a) % 64 : 0), "R5 col_lo",
            int'(dec_col_lo), col ? int'(a) % 64 : 0);
        chk(int'(dec_col_hi) == (col ? ((int'(a) >> 12) * 4 + int'(a[9]) * 2 + int'(a[7])) : 0),
            "R5 col_hi", int'(dec_col_hi),
            col ? ((int'(a) >> 12) * 4 + int'(a[9]) * 2 + int'(a[7])) : 0);
        chk(dec_half == (col && ddr_mode && a[6]), "R6 half", int'(dec_half),
            int'(col && ddr_mode && a[6]));
        chk(dec_autopre == (col && a[8]), "R7 autopre", int'(dec_autopre), int'(col && a[8]));
        chk(int'(dec_illegal) == il_e, act ? "R9 illegal" : "R10 illegal",
            int'(dec_illegal), il_e);
        if (act) tbl_bad[b] = (bad_e != 0);
        @(negedge clk); #1;
        chk(dec_valid == 1'b0, "R4 one-cycle", int'(dec_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) tbl_bad[i] = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(dec_valid == 1'b0, "R1 reset valid", int'(dec_valid), 0);
        @(negedge clk); rst_n = 1'b1;

        // R4: complementary event with nothing pending
        @(negedge clk); ckc_rise = 1'b1; ca_pins = 10'h3ff;
        @(negedge clk); ckc_rise = 1'b0; #1;
        chk(dec_valid == 1'b0, "R4 stray ckc", int'(dec_valid), 0);
        @(negedge clk); #1;
        chk(dec_valid == 1'b0, "R4 stray ckc", int'(dec_valid), 0);

        // R1: reset between the halves
        @(negedge clk); ck_rise = 1'b1; {ras_n, cas_n, we_n} = 3'b101; ca_pins = 10'h155;
        @(negedge clk); ck_rise = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; ckc_rise = 1'b1;
        @(negedge clk); ckc_rise = 1'b0; #1;
        chk(dec_valid == 1'b0, "R1 partial dropped", int'(dec_valid), 0);
        @(negedge clk); #1;
        chk(dec_valid == 1'b0, "R1 partial dropped", int'(dec_valid), 0);

        // R11: restart while waiting for second half
        @(negedge clk); ck_rise = 1'b1; {ras_n, cas_n, we_n} = 3'b011;
        ca_pins = first_half(4'd1, 16'h0000);
        @(negedge clk); {ras_n, cas_n, we_n} = 3'b100;
        ca_pins = first_half(4'd9, 16'h0123);
        @(negedge clk); ck_rise = 1'b0; ckc_rise = 1'b1; ca_pins = second_half(16'h0123);
        @(negedge clk); ckc_rise = 1'b0; #1;
        chk(dec_valid == 1'b1, "R11 restart valid", int'(dec_valid), 1);
        chk(dec_cmd == 3'd3, "R11 restart cmd", int'(dec_cmd), 3);
        chk(dec_bank == 4'd9, "R11 restart bank", int'(dec_bank), 9);
        chk(dec_col_lo == 6'h23, "R11 restart col", int'(dec_col_lo), 'h23);

        // R9/R10 directed: 6G x32, row with A13:12 = 11 in bank 5
        ddr_mode = 1'b0; x16_mode = 1'b0; density = 3'd1;
        send_check(3'b011, 4'd5, 16'h3000);
        send_check(3'b011, 4'd6, 16'h1000);
        send_check(3'b101, 4'd5, 16'h0041);
        send_check(3'b100, 4'd6, 16'h0041);
        density = 3'd3; x16_mode = 1'b1;
        send_check(3'b011, 4'd7, 16'hc000);
        send_check(3'b100, 4'd7, 16'h0100);
        send_check(3'b011, 4'd7, 16'h4000);
        send_check(3'b100, 4'd7, 16'h0100);

        // Sweep: every strobe combination, mode, organisation and density
        for (int c = 0; c < 8; c++) begin
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 5; d++) begin
                    for (int k = 0; k < 4; k++) begin
                        ddr_mode = m[0]; x16_mode = m[1]; density = 3'(d);
                        send_check(3'(c), 4'((k * 5 + c * 3 + d) % 16),
                                   16'((k * 40503 + c * 977 + d * 131 + m * 7919) % 65536));
                    end
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule